// File: doc/BRIEF.md
# Expansion ROM Read Window

This block puts a read-only memory image behind a simple slave port. A requester presents an offset, a transfer size and a read/write flag. The window answers one clock later with a 32-bit result. The image bytes live in a synthesizable array whose contents are computed from parameters, so no file is loaded. Only a prefix of that array, `IMAGE_BYTES` long, is treated as the image.

An `img_present` input says whether an image is fitted. With no image, every read counts as an invalid access and returns all ones. With an image fitted, the block decodes reads in three ways:

- one fixed status offset answers the constant 1, meaning the feature switch is on;
- reads that would run past the end of the image return zero rather than wrapping;
- every other read returns little-endian, zero-extended bytes from the image.

Writes are never accepted. Each write, each reserved size code and each read with no image fitted raises a one-cycle invalid-access strobe. The strobe carries the access type and the size code, so the upstream fabric can log the fault or raise an error on it.

Top module: `xrom_window`

## Requirements
- R1: `req_ready` is always high. A request with `req_valid` high in a clock cycle produces `rsp_valid` high for exactly the next cycle, with the result on `rsp_data`. A cycle without a request produces no `rsp_valid`.
- R2: With `img_present` low, every read (whatever its offset, including the status offset) returns 0xFFFFFFFF and raises the invalid strobe with `bad_write` = 0.
- R3: With `img_present` high, a read of any valid size at offset 0x20018 returns 0x00000001.
- R4: Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes. Code 3 is reserved: a read using it returns 0xFFFFFFFF and raises the invalid strobe.
- R5: A read of n bytes at offset o, with o + n greater than `IMAGE_BYTES` (default 200), returns 0 without an invalid strobe. The sum is formed without wrap-around. A read ending exactly at `IMAGE_BYTES` still returns image data.
- R6: Image byte i holds (i × `MULT` + `SEED`) mod 256 (defaults 29 and 7). Byte o goes to bits 7:0, byte o+1 to bits 15:8 and so on (little-endian). All bits above the transfer size are zero.
- R7: A write raises the invalid strobe with `bad_write` = 1 and returns `rsp_data` = 0. This holds whether or not an image is present. A later read of the same offset returns the unchanged image bytes.
- R8: `bad_pulse` is high for one cycle, only together with `rsp_valid`, and only for the invalid cases of R2, R4 and R7. While it is high, `bad_size` equals that request's size code.
- R9: Reads need no alignment: a halfword or word read may start at any byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| img_present | input | 1 | An image is fitted in the window |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| req_offs | input | OFFS_W (20) | Byte offset into the window |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_data | output | 32 | Read result |
| bad_pulse | output | 1 | Invalid-access strobe |
| bad_write | output | 1 | Invalid access was a write |
| bad_size | output | 2 | Size code of the invalid access |

## Verification
The bench goes after the bounds edge from both sides: reads of each size that end exactly at the image end, and reads one byte further. A design that compared with the wrong inequality would either return data past the image or zero out the final bytes. It also reads at the top of the offset space. There, an adder that wraps would make the bounds test pass and return image data instead of zero. Decode priority is probed with a status-offset read and a write while no image is fitted, and with a reserved size code. A design that ordered the cases wrongly would answer 1 or raise the wrong strobe type. Unaligned halfword and word reads, followed by a read-back after a write, would expose byte-lane swaps, missing zero-extension or a write that leaked into the contents.

// File: rtl/xrom_pkg.sv
// Package: shared types for the expansion ROM read window.
// Assumes size codes 0..2 select 1, 2 and 4 bytes; code 3 is reserved.
package xrom_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        K_DATA   = 3'd0,
        K_STATUS = 3'd1,
        K_ZERO   = 3'd2,
        K_BAD_RD = 3'd3,
        K_BAD_WR = 3'd4
    } resp_kind_e;

    // Number of bytes moved for a size code (0 for the reserved code).
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            SZ_WORD: size_bytes = 3'd4;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/xrom_store.sv
// Module: byte-wide ROM array with a four-lane little-endian fetch.
// The contents are computed from MULT and SEED. Lanes beyond the transfer
// size are forced to zero. Assumes DEPTH_BYTES is a power of two; an index
// past the end wraps, and the classifier never selects such a fetch.
module xrom_store #(
    parameter int DEPTH_BYTES = 256,
    parameter int MULT        = 29,
    parameter int SEED        = 7,
    localparam int IDX_W      = $clog2(DEPTH_BYTES)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output logic [31:0]      word
);
    import xrom_pkg::*;

    logic [7:0] rom_q [DEPTH_BYTES];
    logic [2:0] nbytes;

    // Compute every array entry from its index.
    for (genvar i = 0; i < DEPTH_BYTES; i++) begin : g_rom
        assign rom_q[i] = 8'((i * MULT + SEED) % 256);
    end

    assign nbytes = size_bytes(size);

    // Fetch four consecutive bytes and blank the lanes the size does not use.
    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic [IDX_W-1:0] lane_idx;
        assign lane_idx          = idx + IDX_W'(k);
        assign word[8*k +: 8]    = (3'(k) < nbytes) ? rom_q[lane_idx] : 8'h00;
    end

endmodule

// File: rtl/xrom_classify.sv
// Module: decides how a request is answered.
// Priority: write, no image, reserved size, status offset, out of bounds,
// image data. The end-of-transfer sum carries an extra bit, so a read near
// the top of the offset space cannot wrap back into the image.
module xrom_classify #(
    parameter int          OFFS_W      = 20,
    parameter int          IMAGE_BYTES = 200,
    parameter logic [31:0] STATUS_OFFS = 32'h0002_0018
) (
    input  logic              is_write,
    input  logic              present,
    input  logic [1:0]        size,
    input  logic [OFFS_W-1:0] offs,
    output xrom_pkg::resp_kind_e kind
);
    import xrom_pkg::*;

    localparam logic [OFFS_W:0]   END_LIM = (OFFS_W+1)'(IMAGE_BYTES);
    localparam logic [OFFS_W-1:0] STAT_AT = OFFS_W'(STATUS_OFFS);

    logic [OFFS_W:0] end_sum;

    assign end_sum = {1'b0, offs} + (OFFS_W+1)'(size_bytes(size));

    // Pick the answer class in fixed priority order.
    always_comb begin
        if (is_write)                    kind = K_BAD_WR;
        else if (!present)               kind = K_BAD_RD;
        else if (size == SZ_RSVD)        kind = K_BAD_RD;
        else if (offs == STAT_AT)        kind = K_STATUS;
        else if (end_sum > END_LIM)      kind = K_ZERO;
        else                             kind = K_DATA;
    end

endmodule

// File: rtl/xrom_window.sv
// Module: expansion ROM read window, top level.
// Every request is accepted at once. The answer and the invalid-access
// strobe are registered and appear one clock later. Assumes IMAGE_BYTES
// <= DEPTH_BYTES and that DEPTH_BYTES is a power of two.
module xrom_window #(
    parameter int          OFFS_W      = 20,
    parameter int          DEPTH_BYTES = 256,
    parameter int          IMAGE_BYTES = 200,
    parameter logic [31:0] STATUS_OFFS = 32'h0002_0018,
    parameter int          MULT        = 29,
    parameter int          SEED        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              img_present,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [OFFS_W-1:0] req_offs,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              bad_pulse,
    output logic              bad_write,
    output logic [1:0]        bad_size
);
    import xrom_pkg::*;

    localparam int IDX_W = $clog2(DEPTH_BYTES);

    // Reject parameter sets the block cannot serve.
    if (IMAGE_BYTES > DEPTH_BYTES) begin : g_chk_len
        $error("IMAGE_BYTES exceeds DEPTH_BYTES");
    end
    if ((1 << IDX_W) != DEPTH_BYTES) begin : g_chk_pow2
        $error("DEPTH_BYTES must be a power of two");
    end
    if (IDX_W > OFFS_W) begin : g_chk_offs
        $error("offset narrower than array index");
    end

    resp_kind_e  kind;
    logic [31:0] fetch_word;
    logic [31:0] answer;
    logic        accept;
    logic        is_bad;

    logic        rsp_valid_q;
    logic [31:0] rsp_data_q;
    logic        bad_q;
    logic        bad_write_q;
    logic [1:0]  bad_size_q;

    xrom_classify #(
        .OFFS_W      (OFFS_W),
        .IMAGE_BYTES (IMAGE_BYTES),
        .STATUS_OFFS (STATUS_OFFS)
    ) u_classify (
        .is_write (req_write),
        .present  (img_present),
        .size     (req_size),
        .offs     (req_offs),
        .kind     (kind)
    );

    xrom_store #(
        .DEPTH_BYTES (DEPTH_BYTES),
        .MULT        (MULT),
        .SEED        (SEED)
    ) u_store (
        .idx  (req_offs[IDX_W-1:0]),
        .size (req_size),
        .word (fetch_word)
    );

    assign req_ready = 1'b1;
    assign accept    = req_valid;
    assign is_bad    = (kind == K_BAD_RD) || (kind == K_BAD_WR);

    // Choose the returned value from the answer class.
    always_comb begin
        case (kind)
            K_DATA:   answer = fetch_word;
            K_STATUS: answer = 32'h0000_0001;
            K_BAD_RD: answer = 32'hFFFF_FFFF;
            default:  answer = 32'h0000_0000;
        endcase
    end

    // Register the answer and the invalid-access strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            bad_q       <= 1'b0;
            bad_write_q <= 1'b0;
            bad_size_q  <= '0;
        end else begin
            rsp_valid_q <= accept;
            rsp_data_q  <= accept ? answer : 32'h0;
            bad_q       <= accept && is_bad;
            bad_write_q <= accept && req_write;
            if (accept) bad_size_q <= req_size;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign bad_pulse = bad_q;
    assign bad_write = bad_write_q;
    assign bad_size  = bad_size_q;

    // R1: a response appears exactly one cycle after each request and never otherwise.
    p_rsp_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: a read with no image fitted returns all ones and raises a read fault.
    p_absent_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !img_present) |=>
            (rsp_data == 32'hFFFF_FFFF && bad_pulse && !bad_write));

    // R6: a valid byte read has its upper 24 bits clear.
    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && img_present && req_size == 2'd0) |=>
            (rsp_data[31:8] == 24'h0));

    // R7: a write always yields a write fault and zero data.
    p_write_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (bad_pulse && bad_write && rsp_data == 32'h0));

    // R8: the fault strobe only comes with a response and echoes the size code.
    p_bad_with_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_pulse |-> rsp_valid);
    p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!bad_pulse || bad_size == $past(req_size)));

endmodule

// File: tb/tb_xrom_window.sv
// Scoreboard bench for xrom_window. The driver pushes expected answers
// computed from the requirements; the monitor pops and compares them.
module tb_xrom_window;

    localparam int OFFS_W = 20;
    localparam int IMG    = 200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              img_present = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic [OFFS_W-1:0] req_offs = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_data;
    logic              bad_pulse;
    logic              bad_write;
    logic [1:0]        bad_size;

    xrom_window dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .img_present (img_present),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_size    (req_size),
        .req_offs    (req_offs),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .bad_pulse   (bad_pulse),
        .bad_write   (bad_write),
        .bad_size    (bad_size)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [31:0] d;
        logic        bad;
        logic        bw;
        logic [1:0]  bs;
        int          due;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Image byte i as defined by the content rule (R6).
    function automatic logic [7:0] img_byte(input int i);
        return 8'((i * 29 + 7) % 256);
    endfunction

    // Expected answer from the requirements.
    function automatic exp_t model(input bit w, input bit [1:0] sz, input int offs, input bit pres);
        exp_t e;
        int n;
        e.d = 32'h0; e.bad = 1'b0; e.bw = 1'b0; e.bs = sz; e.due = 0;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        if (w) begin
            e.bad = 1'b1; e.bw = 1'b1;
        end else if (!pres || sz == 2'd3) begin
            e.d = 32'hFFFF_FFFF; e.bad = 1'b1;
        end else if (offs == 32'h20018) begin
            e.d = 32'h1;
        end else if (offs + n > IMG) begin
            e.d = 32'h0;
        end else begin
            for (int k = 0; k < n; k++) e.d[8*k +: 8] = img_byte(offs + k);
        end
        return e;
    endfunction

    // Drive one request at a falling edge and queue its expected answer.
    task automatic issue(input bit w, input bit [1:0] sz, input int offs, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_size  = sz;
        req_offs  = OFFS_W'(offs);
        e = model(w, sz, offs, img_present);
        e.due = cyc + 1;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare each response against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected response: data=%h expected none", rsp_data);
                end else begin
                    exp_t e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if (e.due != cyc) begin
                        errors++;
                        $display("FAIL R1 response cycle: actual %0d expected %0d", cyc, e.due);
                    end
                    if (rsp_data !== e.d || bad_pulse !== e.bad ||
                        (e.bad && (bad_write !== e.bw || bad_size !== e.bs))) begin
                        errors++;
                        $display("FAIL %s: actual data=%h bad=%b bw=%b bs=%0d expected data=%h bad=%b bw=%b bs=%0d",
                                 t, rsp_data, bad_pulse, bad_write, bad_size,
                                 e.d, e.bad, e.bw, e.bs);
                    end
                end
            end else if (expq.size() > 0 && expq[0].due <= cyc) begin
                checks++;
                errors++;
                $display("FAIL R1 missing response for %s: actual rsp_valid=0 expected 1", tagq[0]);
                void'(expq.pop_front());
                void'(tagq.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state (R1)
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || bad_pulse !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: actual valid=%b bad=%b ready=%b expected 0 0 1",
                     rsp_valid, bad_pulse, req_ready);
        end
        rst_n = 1'b1;
        idle(2);

        // Aligned and unaligned image reads (R6, R9)
        issue(0, 2'd0, 0,   "R6 byte at 0");
        idle(1);
        issue(0, 2'd2, 0,   "R6 word at 0");
        issue(0, 2'd1, 1,   "R9 half at 1");
        issue(0, 2'd2, 5,   "R9 word at 5");
        issue(0, 2'd1, 67,  "R9 half at 67");
        issue(0, 2'd0, 131, "R4 byte at 131");
        idle(2);

        // Bounds edge (R5)
        issue(0, 2'd2, 196,     "R5 word ends at image end");
        issue(0, 2'd2, 197,     "R5 word one past end");
        issue(0, 2'd1, 198,     "R5 half ends at image end");
        issue(0, 2'd1, 199,     "R5 half one past end");
        issue(0, 2'd0, 199,     "R5 last byte");
        issue(0, 2'd0, 200,     "R5 byte past end");
        issue(0, 2'd2, 20'hFFFFE, "R5 word at top no wrap");
        issue(0, 2'd0, 20'hFFFFF, "R5 byte at top");
        idle(1);

        // Status offset and reserved size (R3, R4)
        issue(0, 2'd2, 32'h20018, "R3 status word");
        issue(0, 2'd0, 32'h20018, "R3 status byte");
        issue(0, 2'd3, 10,        "R4 reserved size");
        issue(0, 2'd3, 32'h20018, "R4 reserved size at status");
        idle(1);

        // Writes are refused and change nothing (R7, R8)
        issue(1, 2'd2, 8,  "R7 word write");
        issue(0, 2'd2, 8,  "R7 read back after write");
        issue(1, 2'd0, 3,  "R8 byte write size echo");
        issue(0, 2'd0, 3,  "R7 byte read back");
        idle(2);

        // No image fitted (R2, R7)
        @(negedge clk);
        img_present = 1'b0;
        issue(0, 2'd0, 4,         "R2 byte absent");
        issue(0, 2'd2, 0,         "R2 word absent");
        issue(0, 2'd1, 32'h20018, "R2 status absent");
        issue(1, 2'd1, 6,         "R7 write absent");
        idle(1);
        @(negedge clk);
        img_present = 1'b1;
        issue(0, 2'd2, 100, "R6 word after image restored");
        idle(4);

        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R1 outstanding: actual %0d expected 0", expq.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule